// File: doc/BRIEF.md
# Packed BCD to National Character Converter

The block takes a 128-bit signed packed-decimal operand and turns its low seven magnitude digits into 16-bit national numeric characters. The operand's lowest nibble is its sign code. Nibbles 1 through 31 are magnitude digits, with significance rising with the nibble index. Each converted digit becomes a halfword holding the ASCII-style digit code. Halfword 0 of the result holds a sign character.

Alongside the data the block produces a four-bit condition code. The code reports one of three states: negative nonzero, positive nonzero or zero. It also flags two further cases. One is a magnitude that cannot fit in seven digits. The other is an operand whose encoding is not legal.

The conversion itself is combinational. The result and the condition code are captured together into output registers on a single-cycle input strobe, and they hold between strobes.

Top module: `bcd_to_national`

## Requirements
- R1: After reset, and until the first strobe, `nat_out` is all zero and `cc_out` is 4'b0000.
- R2: When `in_valid` is high at a rising clock edge, `nat_out` and `cc_out` take the converted values of `bcd_in` from that edge. While `in_valid` is low, both outputs keep their previous values.
- R3: For i from 1 to 7, halfword i of `nat_out` (bits 16i+15 down to 16i) equals 0x0030 plus digit i of `bcd_in` (bits 4i+3 down to 4i).
- R4: Halfword 0 of `nat_out` is 0x002D when the sign nibble (`bcd_in[3:0]`) is 0xB or 0xD, and 0x002B when it is 0xA, 0xC, 0xE or 0xF.
- R5: The condition code is packed as `cc_out` = {LT, GT, EQ, SO}, with LT in bit 3 and SO in bit 0. For a valid operand, EQ (bit 1) is set when `bcd_in[127:4]` is all zero. Otherwise LT (bit 3) is set for a negative sign and GT (bit 2) for a positive sign. At most one of LT, GT and EQ is ever set.
- R6: For a valid operand, SO (bit 0) is also set when any bit of `bcd_in[127:32]` is nonzero.
- R7: A sign nibble from 0x0 to 0x9 makes the operand invalid, and `cc_out` becomes 4'b0001. The data is then unspecified.
- R8: A digit above 9 in any of nibbles 1 to 7 makes the operand invalid, and `cc_out` becomes 4'b0001. Digits above 9 in nibbles 8 to 31 do not make the operand invalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Capture strobe for the operand |
| bcd_in | input | 128 | Signed packed-decimal operand, sign in bits 3:0 |
| nat_out | output | 128 | Registered national-format result, eight halfwords |
| cc_out | output | 4 | Registered condition code {LT, GT, EQ, SO} |

## Verification
The hardest case to reach is an invalid digit or an overflow sitting right at the edge of the converted field. Examples are a bad nibble at position 7, or a nonzero nibble only at position 8 with the low seven digits zero. Uniform random operands almost never produce a zero low field with a nonzero upper part. The stimulus therefore builds operands digit by digit, with a random significant length. It injects bad sign codes and bad digits at chosen positions. Directed cases cover the boundary nibbles, and a digit above 9 placed above the converted field.

// File: rtl/bcdnat_pkg.sv
package bcdnat_pkg;

    localparam int unsigned NIB_W  = 4;
    localparam int unsigned CHAR_W = 16;

    localparam logic [CHAR_W-1:0] CHAR_MINUS = 16'h002D;
    localparam logic [CHAR_W-1:0] CHAR_PLUS  = 16'h002B;
    localparam logic [CHAR_W-1:0] CHAR_ZERO  = 16'h0030;

    typedef enum logic [1:0] {
        SGN_BAD = 2'd0,
        SGN_POS = 2'd1,
        SGN_NEG = 2'd2
    } sign_kind_e;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cond_code_t;

    function automatic sign_kind_e classify_sign(input logic [NIB_W-1:0] code);
        sign_kind_e k;
        unique case (code)
            4'hB, 4'hD:             k = SGN_NEG;
            4'hA, 4'hC, 4'hE, 4'hF: k = SGN_POS;
            default:                k = SGN_BAD;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/bcdnat_sign_dec.sv
module bcdnat_sign_dec
    import bcdnat_pkg::*;
(
    input  logic [NIB_W-1:0]  sign_nib,
    output logic              sign_neg,
    output logic              sign_ok,
    output logic [CHAR_W-1:0] sign_char
);
    sign_kind_e kind;

    always_comb begin
        kind      = classify_sign(sign_nib);
        sign_neg  = (kind == SGN_NEG);
        sign_ok   = (kind != SGN_BAD);
        sign_char = sign_neg ? CHAR_MINUS : CHAR_PLUS;
    end
endmodule

// File: rtl/bcdnat_digit_enc.sv
module bcdnat_digit_enc
    import bcdnat_pkg::*;
#(
    parameter int unsigned NUM_CONV = 7
) (
    input  logic [NUM_CONV*NIB_W-1:0]  digits,
    output logic [NUM_CONV*CHAR_W-1:0] chars,
    output logic                       any_bad
);
    logic [NUM_CONV-1:0] bad_vec;

    for (genvar g = 0; g < NUM_CONV; g++) begin : g_dig
        logic [NIB_W-1:0] d;
        assign d = digits[g*NIB_W +: NIB_W];
        assign chars[g*CHAR_W +: CHAR_W] = CHAR_ZERO | {{(CHAR_W-NIB_W){1'b0}}, d};
        assign bad_vec[g] = (d > 4'd9);
    end

    assign any_bad = |bad_vec;
endmodule

// File: rtl/bcdnat_cc_gen.sv
module bcdnat_cc_gen
    import bcdnat_pkg::*;
(
    input  logic       sign_ok,
    input  logic       sign_neg,
    input  logic       digit_bad,
    input  logic       mag_zero,
    input  logic       high_nonzero,
    output cond_code_t cc
);
    always_comb begin
        cc = '0;
        if (!sign_ok || digit_bad) begin
            cc.so = 1'b1;
        end else begin
            cc.eq = mag_zero;
            cc.lt = !mag_zero && sign_neg;
            cc.gt = !mag_zero && !sign_neg;
            cc.so = high_nonzero;
        end
    end
endmodule

// File: rtl/bcd_to_national.sv
module bcd_to_national
    import bcdnat_pkg::*;
#(
    parameter int unsigned NUM_CONV = 7,
    parameter int unsigned BCD_W    = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [BCD_W-1:0] bcd_in,
    output logic [BCD_W-1:0] nat_out,
    output logic [3:0]       cc_out
);
    localparam int unsigned CONV_LO  = NIB_W;
    localparam int unsigned CONV_W   = NUM_CONV * NIB_W;
    localparam int unsigned OVF_LSB  = (NUM_CONV + 1) * NIB_W;
    localparam int unsigned CHARS_W  = NUM_CONV * CHAR_W;
    localparam int unsigned USED_W   = CHARS_W + CHAR_W;
    localparam int unsigned PAD_W    = BCD_W - USED_W;

    logic              sign_neg;
    logic              sign_ok;
    logic [CHAR_W-1:0] sign_char;
    logic [CHARS_W-1:0] digit_chars;
    logic              digit_bad;
    logic              mag_zero;
    logic              high_nonzero;
    cond_code_t        cc_next;
    logic [BCD_W-1:0]  nat_next;

    bcdnat_sign_dec u_sign (
        .sign_nib  (bcd_in[NIB_W-1:0]),
        .sign_neg  (sign_neg),
        .sign_ok   (sign_ok),
        .sign_char (sign_char)
    );

    bcdnat_digit_enc #(.NUM_CONV(NUM_CONV)) u_digits (
        .digits  (bcd_in[CONV_LO +: CONV_W]),
        .chars   (digit_chars),
        .any_bad (digit_bad)
    );

    assign mag_zero     = ~|bcd_in[BCD_W-1:NIB_W];
    assign high_nonzero =  |bcd_in[BCD_W-1:OVF_LSB];

    bcdnat_cc_gen u_cc (
        .sign_ok      (sign_ok),
        .sign_neg     (sign_neg),
        .digit_bad    (digit_bad),
        .mag_zero     (mag_zero),
        .high_nonzero (high_nonzero),
        .cc           (cc_next)
    );

    if (PAD_W > 0) begin : g_pad
        assign nat_next = {{PAD_W{1'b0}}, digit_chars, sign_char};
    end else begin : g_nopad
        assign nat_next = {digit_chars, sign_char};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nat_out <= '0;
            cc_out  <= '0;
        end else if (in_valid) begin
            nat_out <= nat_next;
            cc_out  <= cc_next;
        end
    end
endmodule

// File: rtl/bcd_to_national_chk.sv
module bcd_to_national_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [127:0] bcd_in,
    input logic [127:0] nat_out,
    input logic [3:0]   cc_out
);
    // R7
    bad_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bcd_in[3:0] <= 4'd9) |=> (cc_out == 4'b0001));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(nat_out) && $stable(cc_out)));

    // R5
    cc_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cc_out[3:1]) <= 1);

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (|bcd_in[127:32])) |=> cc_out[0]);

    // R4
    neg_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (bcd_in[3:0] == 4'hB || bcd_in[3:0] == 4'hD))
        |=> (nat_out[15:0] == 16'h002D));
endmodule

bind bcd_to_national bcd_to_national_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .bcd_in   (bcd_in),
    .nat_out  (nat_out),
    .cc_out   (cc_out)
);

// File: tb/tb_bcd_to_national.sv
`timescale 1ns/1ps
module tb_bcd_to_national;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] bcd_in = '0;
    logic [127:0] nat_out;
    logic [3:0]   cc_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    bcd_to_national dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .bcd_in(bcd_in), .nat_out(nat_out), .cc_out(cc_out)
    );

    function automatic logic [3:0] ref_cc(input logic [127:0] b);
        logic bad;
        logic neg;
        logic [3:0] s;
        s = b[3:0];
        bad = (s <= 4'd9);
        neg = (s == 4'hB) || (s == 4'hD);
        for (int i = 1; i <= 7; i++)
            if (b[4*i +: 4] > 4'd9) bad = 1'b1;
        if (bad) return 4'b0001;
        if (b[127:4] == '0) return 4'b0010;
        return {neg, !neg, 1'b0, (b[127:32] != '0)};
    endfunction

    function automatic logic [127:0] ref_nat(input logic [127:0] b);
        logic [127:0] r;
        r = '0;
        r[15:0] = ((b[3:0] == 4'hB) || (b[3:0] == 4'hD)) ? 16'h002D : 16'h002B;
        for (int i = 1; i <= 7; i++)
            r[16*i +: 16] = 16'h0030 + {12'h000, b[4*i +: 4]};
        return r;
    endfunction

    task automatic check_cc(input string req, input logic [3:0] exp);
        checks++;
        if (cc_out !== exp) begin
            errors++;
            $display("FAIL %s cc_out actual=%b expected=%b", req, cc_out, exp);
        end
    endtask

    task automatic check_nat(input string req, input logic [127:0] exp);
        checks++;
        if (nat_out !== exp) begin
            errors++;
            $display("FAIL %s nat_out actual=%h expected=%h", req, nat_out, exp);
        end
    endtask

    // strobe one operand, then check at the following falling edge
    task automatic apply(input string req, input logic [127:0] b);
        logic [3:0] ec;
        @(negedge clk);
        bcd_in = b;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        ec = ref_cc(b);
        check_cc(req, ec);
        if (ec != 4'b0001) check_nat(req, ref_nat(b));
    endtask

    function automatic logic [3:0] pick_sign(input int unsigned r);
        logic [3:0] t [6];
        t = '{4'hA, 4'hB, 4'hC, 4'hD, 4'hE, 4'hF};
        return t[r % 6];
    endfunction

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [127:0] b;
        logic [127:0] held_nat;
        logic [3:0]   held_cc;
        int unsigned  seed;
        int unsigned  len;
        seed = 32'd12345;
        void'($urandom(seed));

        repeat (3) @(negedge clk);
        // R1 reset values
        check_nat("R1", '0);
        check_cc("R1", 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        check_nat("R1", '0);
        check_cc("R1", 4'b0000);

        // R3 R4 R5 directed
        apply("R3", 128'h0000_0000_0000_0000_0000_0000_7654_321C);
        apply("R4", 128'h0000_0000_0000_0000_0000_0000_9876_543D);
        apply("R4", 128'h0000_0000_0000_0000_0000_0000_0000_001B);
        apply("R4", 128'h0000_0000_0000_0000_0000_0000_0000_005E);
        apply("R5", 128'h0000_0000_0000_0000_0000_0000_0000_000D);
        apply("R5", 128'h0000_0000_0000_0000_0000_0000_0000_000F);
        // R6 overflow boundaries
        apply("R6", 128'h0000_0000_0000_0000_0000_0001_0000_000C);
        apply("R6", 128'h9000_0000_0000_0000_0000_0000_0000_001B);
        apply("R6", 128'h0000_0000_0000_0000_0000_0000_9999_999A);
        // R7 bad signs
        apply("R7", 128'h0000_0000_0000_0000_0000_0000_0000_1239);
        apply("R7", 128'h0000_0000_0000_0000_0000_0000_0000_0000);
        apply("R7", 128'h0000_0000_0000_0000_0000_0001_0000_0125);
        // R8 bad digits at field edges, and above the field
        apply("R8", 128'h0000_0000_0000_0000_0000_0000_0000_00AC);
        apply("R8", 128'h0000_0000_0000_0000_0000_0000_F000_000D);
        apply("R8", 128'h0000_0000_0000_0000_0000_000E_0000_000C);

        // R2 hold while strobe low
        apply("R2", 128'h0000_0000_0000_0000_0000_0000_0000_042C);
        held_nat = ref_nat(128'h42C);
        held_cc  = ref_cc(128'h42C);
        @(negedge clk);
        bcd_in = 128'h0000_0000_0000_0000_0000_0000_1111_111D;
        repeat (2) @(negedge clk);
        check_nat("R2", held_nat);
        check_cc("R2", held_cc);

        // random mix
        for (int n = 0; n < 400; n++) begin
            b = '0;
            len = $urandom % 32;
            for (int i = 1; i <= 31; i++)
                if (i <= len) b[4*i +: 4] = 4'($urandom % 10);
            b[3:0] = pick_sign($urandom);
            if ($urandom % 8 == 0) b[3:0] = 4'($urandom % 10);
            if ($urandom % 8 == 0) b[4*(1 + $urandom % 7) +: 4] = 4'(10 + $urandom % 6);
            if ($urandom % 6 == 0) b[31:4] = '0;
            apply("R3 R5 R6 R7 R8 random", b);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule